// File: doc/BRIEF.md
# Instruction Class Decoder

This block looks at one 32-bit instruction word together with the four arithmetic flags. It tells the rest of a pipeline whether the instruction should run, and which of the less common formats it belongs to. Those formats are branch-with-exchange, the short and long multiplies, the atomic swap, the halfword and signed-load transfers, and the three status-register moves. For a matched class the block also pulls out the operand fields. Those are the register indices, the offset or rotated immediate, and the single-bit modifiers. Every other word is reported as "other" so that a separate decoder can take it.

Classification never looks at the whole word. A 12-bit key is built from bits 27:20, placed above bits 7:4, and matched against wildcard patterns in a fixed priority order. The condition field in bits 31:28 is evaluated in parallel against the flags. The results are captured in an output register, which a parameter can bypass to give a purely combinational path.

Top module: `idec_top`

## Requirements
- R1: `exec_en_o` is the condition test of bits 31:28 against `flags_i`, where flags_i[3]=N, [2]=Z, [1]=C and [0]=V. The codes are evaluated as follows:
  - 0: Z. 1: !Z.
  - 2: C. 3: !C.
  - 4: N. 5: !N.
  - 6: V. 7: !V.
  - 8: C&!Z. 9: !C|Z.
  - A: N==V. B: N!=V.
  - C: !Z&(N==V). D: Z|(N!=V).
  - E: always 1. F: always 0.
- R2: The key {instr[27:20], instr[7:4]} equal to {8'h12, 4'h1} gives class 1 (exchange-branch), with `rm_o` = instr[3:0].
- R3: Key {000000??, 1001} gives class 2 (multiply). `acc_o` = bit 21 and `setf_o` = bit 20. The register fields are `rd_o` = 19:16, `rn_o` = 15:12, `rs_o` = 11:8 and `rm_o` = 3:0.
- R4: Key {00001???, 1001} gives class 3 (long multiply). `sign_o` = bit 22, `acc_o` = bit 21 and `setf_o` = bit 20. The high destination appears on `rd_o` (19:16) and the low destination on `rn_o` (15:12). `rs_o` = 11:8 and `rm_o` = 3:0.
- R5: Key {00010?00, 1001} gives class 4 (swap), with `byte_o` = bit 22, `rn_o` = 19:16, `rd_o` = 15:12 and `rm_o` = 3:0. Multiply, long multiply and swap are matched ahead of the transfer classes.
- R6: Key {000?????, 1011} gives class 5 (halfword transfer). The outputs are `half_o`=1 and `sign_o`=0, with `load_o` = bit 20. `pre_o`, `up_o` and `wb_o` come from bits 24, 23 and 21. The base register is on `rn_o` (19:16) and the data register on `rd_o` (15:12).
- R7: Key {000????1, 11?1} gives class 6 (signed load), with `sign_o`=1, `load_o`=1 and `half_o` = bit 5. The same pattern with bit 20 clear is class 0.
- R8: In classes 5 and 6, `imm_sel_o` = bit 22. When it is set, `imm_o` = {instr[11:8], instr[3:0]} and `rm_o` = 0. When it is clear, `rm_o` = 3:0 and `imm_o` = 0.
- R9: The status-register moves are classified as follows:
  - Key {00010?00, 0000} is class 7 (read status), with `rd_o` = 15:12.
  - Key {00010?10, 0000} is class 8 (write status from a register), with `rm_o` = 3:0.
  - Key {00110?10, any} is class 9 (write status from an immediate), with `imm_o` = 7:0 and `rot_o` = 11:8.
  - In classes 8 and 9 the field mask 19:16 appears on `rn_o`.
  - In all three classes `psr_sel_o` = bit 22.
- R10: Any other key gives class 0. In class 0 every field output and every modifier bit is 0, while `exec_en_o` still follows R1.
- R11: With `REG_OUT`=1 the outputs change one clock edge after the inputs. A reset edge clears all outputs to 0, that is class 0 with `exec_en_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| flags_i | input | 4 | N, Z, C, V flags (bit 3 down to 0) |
| cls_o | output | 4 | Class code |
| exec_en_o | output | 1 | Condition passed |
| rd_o | output | 4 | Destination / high destination / data register |
| rn_o | output | 4 | Base / accumulate / low destination / field mask |
| rs_o | output | 4 | Multiplier shift register |
| rm_o | output | 4 | Operand register |
| imm_o | output | 8 | Transfer offset or status immediate |
| rot_o | output | 4 | Rotate for status immediate |
| imm_sel_o | output | 1 | Transfer offset is immediate |
| pre_o | output | 1 | Pre-index |
| up_o | output | 1 | Add offset |
| wb_o | output | 1 | Write back base |
| load_o | output | 1 | Load direction |
| half_o | output | 1 | Halfword size |
| sign_o | output | 1 | Signed |
| acc_o | output | 1 | Accumulate |
| setf_o | output | 1 | Set flags |
| byte_o | output | 1 | Byte swap |
| psr_sel_o | output | 1 | Saved status register selected |

## Verification
The hardest keys to reach are those that sit right next to a neighbour's pattern. A 1101 signed pattern with the load bit clear must fall to "other". A status write from a register differs from exchange-branch only in bits 7:4. A swap shares its low nibble with the multiplies. The stimulus table places these near-miss words beside the real encodings so that each can be checked for misclassification. The condition evaluator is driven through flag combinations that split each paired code, for example GE against LT and LS against HI.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int INSN_W  = 32;
  localparam int FLAG_W  = 4;
  localparam int REG_W   = 4;
  localparam int IMM_W   = 8;
  localparam int ROT_W   = 4;
  localparam int KEY_W   = 12;
  localparam int CLS_W   = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_OTHER   = 4'd0,
    CLS_BX      = 4'd1,
    CLS_MUL     = 4'd2,
    CLS_MULL    = 4'd3,
    CLS_SWAP    = 4'd4,
    CLS_HALF    = 4'd5,
    CLS_SLOAD   = 4'd6,
    CLS_MRS     = 4'd7,
    CLS_MSR_REG = 4'd8,
    CLS_MSR_IMM = 4'd9
  } iclass_e;

  typedef struct packed {
    iclass_e           cls;
    logic              exec_en;
    logic [REG_W-1:0]  rd;
    logic [REG_W-1:0]  rn;
    logic [REG_W-1:0]  rs;
    logic [REG_W-1:0]  rm;
    logic [IMM_W-1:0]  imm;
    logic [ROT_W-1:0]  rot;
    logic              imm_sel;
    logic              pre;
    logic              up;
    logic              wb;
    logic              load;
    logic              half;
    logic              sign;
    logic              acc;
    logic              setf;
    logic              byte_sel;
    logic              psr_sel;
  } idec_t;
endpackage

// File: rtl/idec_cond.sv
module idec_cond
  import idec_pkg::*;
(
  input  logic [3:0]        cond_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              pass_o
);
  logic n_f, z_f, c_f, v_f;
  assign n_f = flags_i[3];
  assign z_f = flags_i[2];
  assign c_f = flags_i[1];
  assign v_f = flags_i[0];

  always_comb begin
    unique case (cond_i)
      4'h0: pass_o = z_f;
      4'h1: pass_o = !z_f;
      4'h2: pass_o = c_f;
      4'h3: pass_o = !c_f;
      4'h4: pass_o = n_f;
      4'h5: pass_o = !n_f;
      4'h6: pass_o = v_f;
      4'h7: pass_o = !v_f;
      4'h8: pass_o = c_f && !z_f;
      4'h9: pass_o = !c_f || z_f;
      4'hA: pass_o = (n_f == v_f);
      4'hB: pass_o = (n_f != v_f);
      4'hC: pass_o = !z_f && (n_f == v_f);
      4'hD: pass_o = z_f || (n_f != v_f);
      4'hE: pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/idec_classify.sv
module idec_classify
  import idec_pkg::*;
(
  input  logic [KEY_W-1:0] key_i,
  output iclass_e          cls_o
);
  // First matching pattern wins; multiply and swap precede transfers.
  always_comb begin
    casez (key_i)
      12'b0001_0010_0001: cls_o = CLS_BX;
      12'b0001_0?00_0000: cls_o = CLS_MRS;
      12'b0001_0?10_0000: cls_o = CLS_MSR_REG;
      12'b0011_0?10_????: cls_o = CLS_MSR_IMM;
      12'b0000_00??_1001: cls_o = CLS_MUL;
      12'b0000_1???_1001: cls_o = CLS_MULL;
      12'b0001_0?00_1001: cls_o = CLS_SWAP;
      12'b000?_????_1011: cls_o = CLS_HALF;
      12'b000?_???1_11?1: cls_o = CLS_SLOAD;
      default:            cls_o = CLS_OTHER;
    endcase
  end
endmodule

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
(
  input  logic [INSN_W-1:0] instr_i,
  input  iclass_e           cls_i,
  input  logic              pass_i,
  output idec_t             dec_o
);
  logic [REG_W-1:0] f_hi, f_mid, f_s, f_lo;
  assign f_hi  = instr_i[19:16];
  assign f_mid = instr_i[15:12];
  assign f_s   = instr_i[11:8];
  assign f_lo  = instr_i[3:0];

  always_comb begin
    dec_o         = '0;
    dec_o.cls     = cls_i;
    dec_o.exec_en = pass_i;
    unique case (cls_i)
      CLS_BX: dec_o.rm = f_lo;
      CLS_MUL, CLS_MULL: begin
        dec_o.rd   = f_hi;
        dec_o.rn   = f_mid;
        dec_o.rs   = f_s;
        dec_o.rm   = f_lo;
        dec_o.acc  = instr_i[21];
        dec_o.setf = instr_i[20];
        dec_o.sign = (cls_i == CLS_MULL) ? instr_i[22] : 1'b0;
      end
      CLS_SWAP: begin
        dec_o.rn       = f_hi;
        dec_o.rd       = f_mid;
        dec_o.rm       = f_lo;
        dec_o.byte_sel = instr_i[22];
      end
      CLS_HALF, CLS_SLOAD: begin
        dec_o.rn      = f_hi;
        dec_o.rd      = f_mid;
        dec_o.pre     = instr_i[24];
        dec_o.up      = instr_i[23];
        dec_o.wb      = instr_i[21];
        dec_o.load    = instr_i[20];
        dec_o.imm_sel = instr_i[22];
        dec_o.half    = (cls_i == CLS_HALF) ? 1'b1 : instr_i[5];
        dec_o.sign    = (cls_i == CLS_SLOAD);
        if (instr_i[22]) dec_o.imm = {f_s, f_lo};
        else             dec_o.rm  = f_lo;
      end
      CLS_MRS: begin
        dec_o.rd      = f_mid;
        dec_o.psr_sel = instr_i[22];
      end
      CLS_MSR_REG: begin
        dec_o.rn      = f_hi;
        dec_o.rm      = f_lo;
        dec_o.psr_sel = instr_i[22];
      end
      CLS_MSR_IMM: begin
        dec_o.rn      = f_hi;
        dec_o.imm     = instr_i[7:0];
        dec_o.rot     = f_s;
        dec_o.psr_sel = instr_i[22];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/idec_top.sv
module idec_top
  import idec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSN_W-1:0]  instr_i,
  input  logic [FLAG_W-1:0]  flags_i,
  output logic [CLS_W-1:0]   cls_o,
  output logic               exec_en_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [REG_W-1:0]   rn_o,
  output logic [REG_W-1:0]   rs_o,
  output logic [REG_W-1:0]   rm_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic [ROT_W-1:0]   rot_o,
  output logic               imm_sel_o,
  output logic               pre_o,
  output logic               up_o,
  output logic               wb_o,
  output logic               load_o,
  output logic               half_o,
  output logic               sign_o,
  output logic               acc_o,
  output logic               setf_o,
  output logic               byte_o,
  output logic               psr_sel_o
);
  logic [KEY_W-1:0] key;
  logic             pass;
  iclass_e          cls;
  idec_t            dec_c;
  idec_t            dec_q;

  assign key = {instr_i[27:20], instr_i[7:4]};

  idec_cond u_cond (
    .cond_i  (instr_i[31:28]),
    .flags_i (flags_i),
    .pass_o  (pass)
  );

  idec_classify u_cls (
    .key_i (key),
    .cls_o (cls)
  );

  idec_fields u_fld (
    .instr_i (instr_i),
    .cls_i   (cls),
    .pass_i  (pass),
    .dec_o   (dec_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec_c;
      end
    end else begin : g_comb
      assign dec_q = dec_c;
    end
  endgenerate

  assign cls_o     = dec_q.cls;
  assign exec_en_o = dec_q.exec_en;
  assign rd_o      = dec_q.rd;
  assign rn_o      = dec_q.rn;
  assign rs_o      = dec_q.rs;
  assign rm_o      = dec_q.rm;
  assign imm_o     = dec_q.imm;
  assign rot_o     = dec_q.rot;
  assign imm_sel_o = dec_q.imm_sel;
  assign pre_o     = dec_q.pre;
  assign up_o      = dec_q.up;
  assign wb_o      = dec_q.wb;
  assign load_o    = dec_q.load;
  assign half_o    = dec_q.half;
  assign sign_o    = dec_q.sign;
  assign acc_o     = dec_q.acc;
  assign setf_o    = dec_q.setf;
  assign byte_o    = dec_q.byte_sel;
  assign psr_sel_o = dec_q.psr_sel;
endmodule

// File: rtl/idec_checker.sv
module idec_checker #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr_i,
  input logic [3:0]  flags_i,
  input logic [3:0]  cls_o,
  input logic        exec_en_o,
  input logic [3:0]  rd_o,
  input logic [3:0]  rn_o,
  input logic [3:0]  rs_o,
  input logic [3:0]  rm_o,
  input logic [7:0]  imm_o,
  input logic        load_o,
  input logic        sign_o,
  input logic        half_o
);
  generate
    if (REG_OUT) begin : g_chk
      p_never_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_i[31:28]) == 4'hF) |-> !exec_en_o);

      p_always_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_i[31:28]) == 4'hE) |-> exec_en_o);

      p_bx_key_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_i[27:20]) == 8'h12 && $past(instr_i[7:4]) == 4'h1)
        |-> cls_o == 4'd1);

      p_sload_dir_r7: assert property (@(posedge clk) disable iff (rst)
        cls_o == 4'd6 |-> (load_o && sign_o));

      p_half_flag_r6: assert property (@(posedge clk) disable iff (rst)
        cls_o == 4'd5 |-> (half_o && !sign_o));

      p_other_zero_r10: assert property (@(posedge clk) disable iff (rst)
        cls_o == 4'd0 |-> (rd_o == 4'd0 && rn_o == 4'd0 && rs_o == 4'd0 &&
                           rm_o == 4'd0 && imm_o == 8'd0 && !load_o && !sign_o));

      p_reset_r11: assert property (@(posedge clk)
        rst |=> (cls_o == 4'd0 && !exec_en_o));

      p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable(instr_i) && $stable(flags_i)) |=>
        ($stable(cls_o) && $stable(exec_en_o)));
    end
  endgenerate
endmodule

bind idec_top idec_checker #(.REG_OUT(REG_OUT)) u_idec_chk (
  .clk       (clk),
  .rst       (rst),
  .instr_i   (instr_i),
  .flags_i   (flags_i),
  .cls_o     (cls_o),
  .exec_en_o (exec_en_o),
  .rd_o      (rd_o),
  .rn_o      (rn_o),
  .rs_o      (rs_o),
  .rm_o      (rm_o),
  .imm_o     (imm_o),
  .load_o    (load_o),
  .sign_o    (sign_o),
  .half_o    (half_o)
);

// File: tb/test_idec_top.sv
module test_idec_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_i = 32'h0;
  logic [3:0]  flags_i = 4'h0;
  logic [3:0]  cls_o;
  logic        exec_en_o;
  logic [3:0]  rd_o, rn_o, rs_o, rm_o, rot_o;
  logic [7:0]  imm_o;
  logic        imm_sel_o, pre_o, up_o, wb_o, load_o, half_o, sign_o;
  logic        acc_o, setf_o, byte_o, psr_sel_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  idec_top i_idec_top (
    .clk(clk), .rst(rst), .instr_i(instr_i), .flags_i(flags_i),
    .cls_o(cls_o), .exec_en_o(exec_en_o), .rd_o(rd_o), .rn_o(rn_o),
    .rs_o(rs_o), .rm_o(rm_o), .imm_o(imm_o), .rot_o(rot_o),
    .imm_sel_o(imm_sel_o), .pre_o(pre_o), .up_o(up_o), .wb_o(wb_o),
    .load_o(load_o), .half_o(half_o), .sign_o(sign_o), .acc_o(acc_o),
    .setf_o(setf_o), .byte_o(byte_o), .psr_sel_o(psr_sel_o)
  );

  // {instr, flags, class, exec_en}
  localparam int NV = 24;
  localparam logic [40:0] VEC [NV] = '{
    {32'hE12FFF13, 4'h0, 4'd1, 1'b1},  // R2 exchange-branch
    {32'hE0000291, 4'h0, 4'd2, 1'b1},  // R3 multiply
    {32'hE0200291, 4'h0, 4'd2, 1'b1},  // R3 multiply-accumulate
    {32'hE0810392, 4'h0, 4'd3, 1'b1},  // R4 long multiply
    {32'hE1020091, 4'h0, 4'd4, 1'b1},  // R5 swap
    {32'hE1420091, 4'h0, 4'd4, 1'b1},  // R5 swap byte
    {32'hE1D100B2, 4'h0, 4'd5, 1'b1},  // R6 halfword
    {32'hE19100D1, 4'h0, 4'd6, 1'b1},  // R7 signed byte load
    {32'hE09100F1, 4'h0, 4'd6, 1'b1},  // R7 signed half load
    {32'hE10000D1, 4'h0, 4'd0, 1'b1},  // R7 signed store -> other
    {32'hE10F0000, 4'h0, 4'd7, 1'b1},  // R9 read status
    {32'hE129F003, 4'h0, 4'd8, 1'b1},  // R9 write status reg
    {32'hE328F0FF, 4'h0, 4'd9, 1'b1},  // R9 write status imm
    {32'hE0810002, 4'h0, 4'd0, 1'b1},  // R10 data op
    {32'hEA000000, 4'h0, 4'd0, 1'b1},  // R10 branch
    {32'h012FFF13, 4'h4, 4'd1, 1'b1},  // R1 EQ, Z=1
    {32'h012FFF13, 4'h0, 4'd1, 1'b0},  // R1 EQ, Z=0
    {32'hF12FFF13, 4'hF, 4'd1, 1'b0},  // R1 never
    {32'h812FFF13, 4'h2, 4'd1, 1'b1},  // R1 HI
    {32'h912FFF13, 4'h2, 4'd1, 1'b0},  // R1 LS
    {32'hA12FFF13, 4'h9, 4'd1, 1'b1},  // R1 GE N=V=1
    {32'hB12FFF13, 4'h9, 4'd1, 1'b0},  // R1 LT N=V=1
    {32'hC12FFF13, 4'h0, 4'd1, 1'b1},  // R1 GT
    {32'hD12FFF13, 4'h4, 4'd1, 1'b1}   // R1 LE
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [3:0] fl);
    @(negedge clk);
    instr_i = ins;
    flags_i = fl;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    instr_i = 32'hE12FFF13;
    repeat (3) @(posedge clk);
    #1;
    chk(cls_o == 4'd0 && !exec_en_o && rm_o == 4'd0, "R11 reset", {cls_o, 3'b0, exec_en_o}, 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][40:9], VEC[i][8:5]);
      chk(cls_o == VEC[i][4:1], $sformatf("R2-class vec%0d R10", i), cls_o, VEC[i][4:1]);
      chk(exec_en_o == VEC[i][0], $sformatf("R1 vec%0d", i), exec_en_o, VEC[i][0]);
    end

    apply(32'hE12FFF13, 4'h0);
    chk(rm_o == 4'd3, "R2 rm", rm_o, 3);

    apply(32'hE0312394, 4'h0);
    chk({rd_o, rn_o, rs_o, rm_o} == 16'h1234 && acc_o && setf_o && !sign_o,
        "R3 fields", {rd_o, rn_o, rs_o, rm_o, acc_o, setf_o, sign_o}, 32'h1234_6 >> 0);

    apply(32'hE0D12394, 4'h0);
    chk({rd_o, rn_o, rs_o, rm_o} == 16'h1234 && sign_o && !acc_o && setf_o,
        "R4 fields", {rd_o, rn_o, rs_o, rm_o, sign_o, acc_o, setf_o}, {16'h1234, 3'b101});

    apply(32'hE1475098, 4'h0);
    chk(cls_o == 4'd4 && rn_o == 4'd7 && rd_o == 4'd5 && rm_o == 4'd8 && byte_o,
        "R5 swap fields", {cls_o, rn_o, rd_o, rm_o, byte_o}, {4'd4, 4'd7, 4'd5, 4'd8, 1'b1});

    apply(32'hE1F542B3, 4'h0);
    chk(cls_o == 4'd5 && rn_o == 4'd5 && rd_o == 4'd4 && pre_o && up_o && wb_o &&
        load_o && half_o && !sign_o, "R6 halfword fields",
        {cls_o, rn_o, rd_o, pre_o, up_o, wb_o, load_o, half_o, sign_o},
        {4'd5, 4'd5, 4'd4, 6'b111110});
    chk(imm_sel_o && imm_o == 8'h23 && rm_o == 4'd0, "R8 immediate offset",
        {imm_sel_o, imm_o, rm_o}, {1'b1, 8'h23, 4'd0});

    apply(32'hE01540B3, 4'h0);
    chk(!imm_sel_o && imm_o == 8'h00 && rm_o == 4'd3 && !pre_o && !up_o && !wb_o && load_o,
        "R8 register offset", {imm_sel_o, imm_o, rm_o}, {1'b0, 8'h00, 4'd3});

    apply(32'hE1D420F3, 4'h0);
    chk(cls_o == 4'd6 && half_o && sign_o && load_o && imm_sel_o && imm_o == 8'h03,
        "R7 signed half", {cls_o, half_o, sign_o, load_o}, {4'd6, 3'b111});

    apply(32'hE1D420D3, 4'h0);
    chk(cls_o == 4'd6 && !half_o && sign_o, "R7 signed byte", {cls_o, half_o, sign_o}, {4'd6, 2'b01});

    apply(32'hE362F1AB, 4'h0);
    chk(cls_o == 4'd9 && rn_o == 4'd2 && rot_o == 4'd1 && imm_o == 8'hAB && psr_sel_o,
        "R9 status imm", {cls_o, rn_o, rot_o, imm_o, psr_sel_o}, {4'd9, 4'd2, 4'd1, 8'hAB, 1'b1});

    apply(32'hE14F7000, 4'h0);
    chk(cls_o == 4'd7 && rd_o == 4'd7 && psr_sel_o, "R9 read status", {cls_o, rd_o}, {4'd7, 4'd7});

    apply(32'hE12CF00A, 4'h0);
    chk(cls_o == 4'd8 && rn_o == 4'hC && rm_o == 4'hA && !psr_sel_o,
        "R9 status reg", {cls_o, rn_o, rm_o}, {4'd8, 4'hC, 4'hA});

    apply(32'hE0812345, 4'h0);
    chk(cls_o == 4'd0 && rd_o == 0 && rn_o == 0 && rs_o == 0 && rm_o == 0 && imm_o == 0 &&
        !load_o && !acc_o && exec_en_o, "R10 other zero",
        {cls_o, rd_o, rn_o, rs_o, rm_o}, 0);

    // R11 latency: new input not visible before the next edge
    @(negedge clk);
    instr_i = 32'hE12FFF13;
    #1;
    chk(cls_o == 4'd0, "R11 latency before edge", cls_o, 0);
    @(posedge clk);
    #1;
    chk(cls_o == 4'd1, "R11 latency after edge", cls_o, 1);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(cls_o == 4'd0 && !exec_en_o, "R11 reset mid-run", {cls_o, exec_en_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule